// File: doc/BRIEF.md
# Serial Divider Programming Front End

This block is the three-wire loading port of a frequency synthesizer. A controller drives three lines: a shift clock, a serial data line and a latch-enable line. On each rising shift-clock edge one data bit enters a shift register. The last bit shifted in is a steering bit. When the enable line goes high, the steering bit decides which target receives the bits before it. A steering bit of 1 selects the 14-bit reference-divider value. A steering bit of 0 selects the combined pair of a 10-bit main divider and a 7-bit auxiliary divider.

The three lines are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the block detects edges in the system-clock domain. While the enable line is low, the controller can shift freely and the held divider values do not change. While the enable line is high, the selected target follows the shift register. On the rising edge of the enable line, the block gives a single-cycle update strobe for the group that was written, so that the downstream counters can reload.

Top module: `divLatchLoader`

## Requirements
- R1: After reset, the reference, main and auxiliary values are zero and both update strobes are low.
- R2: Exactly one bit enters the shift register per rising edge of the shift clock. Changes on the data line without a rising shift-clock edge shift nothing.
- R3: With the enable line high and a final bit of 1, the reference value takes the 14 bits shifted in just before that final bit. The earliest of those 14 bits is the MSB.
- R4: With the enable line high and a final bit of 0, the main value takes the first 10 of the 17 preceding bits, MSB first. The auxiliary value takes the next 7 bits, MSB first.
- R5: While the enable line is low, shifting any bits leaves the reference, main and auxiliary values unchanged.
- R6: A reference load leaves the main and auxiliary values unchanged. A main/auxiliary load leaves the reference value unchanged.
- R7: Each rising edge of the enable line gives exactly one single-cycle strobe. The strobe is r_update (port rUpdate) when the final bit is 1 and na_update (port naUpdate) when it is 0, and the two are never high together.
- R8: Bits shifted in ahead of a frame fall off the far end and do not affect the loaded value.
- R9: While the enable line is held high, further shifting keeps updating the selected target and produces no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial shift clock (asynchronous) |
| sdataIn | input | 1 | Serial data (asynchronous) |
| latchEnIn | input | 1 | Latch enable, level sensitive (asynchronous) |
| rValue | output | 14 | Latched reference-divider value |
| nValue | output | 10 | Latched main-divider value |
| aValue | output | 7 | Latched auxiliary-divider value |
| rUpdate | output | 1 | One-cycle strobe after a reference load |
| naUpdate | output | 1 | One-cycle strobe after a main/auxiliary load |

## Verification
A change on any input line reaches the logic after two synchronizer flops. On the third system-clock edge, a shift, a latch load and an update strobe all take effect together. The bench holds every line level for four or more system cycles and waits eight cycles after raising or lowering the enable line before it samples on a falling clock edge, so each result is already settled. Strobes are counted on every rising edge for the whole run. A check therefore compares the pulse count before and after an enable pulse, which shows both the one-cycle width and the right target.

// File: rtl/divLoadPkg.sv
package divLoadPkg;
  // strobes from control to datapath, all in the system-clock domain
  typedef struct packed {
    logic shift;   // one-cycle: a shift-clock rising edge was seen
    logic bitIn;   // synchronized data bit
    logic load;    // level: synchronized enable is high
    logic pulse;   // one-cycle: enable rising edge
  } ctrlStrobes_t;
endpackage

// File: rtl/divLoadCtrl.sv
module divLoadCtrl
  import divLoadPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkIn,
  input  logic         sdataIn,
  input  logic         latchEnIn,
  output ctrlStrobes_t strb
);
  localparam int SIG_W = 3;

  logic [SIG_W-1:0] syncPipe [SYNC_STAGES];
  logic sclkSync, dataSync, enSync;
  logic sclkPrev, enPrev;

  assign {enSync, dataSync, sclkSync} = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= '0;
      sclkPrev <= 1'b0;
      enPrev   <= 1'b0;
    end else begin
      syncPipe[0] <= {latchEnIn, sdataIn, sclkIn};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
      sclkPrev <= sclkSync;
      enPrev   <= enSync;
    end
  end

  always_comb begin
    strb.shift = sclkSync & ~sclkPrev;
    strb.bitIn = dataSync;
    strb.load  = enSync;
    strb.pulse = enSync & ~enPrev;
  end

  // R2: a held-high shift clock yields a single shift
  a_r2_single_shift: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> !strb.shift);
  // R7: a held-high enable yields a single pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.pulse |=> !strb.pulse);
endmodule

// File: rtl/divLoadDatapath.sv
module divLoadDatapath
  import divLoadPkg::*;
#(
  parameter int R_W = 14,
  parameter int N_W = 10,
  parameter int A_W = 7
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobes_t   strb,
  output logic [R_W-1:0] rValue,
  output logic [N_W-1:0] nValue,
  output logic [A_W-1:0] aValue,
  output logic           rUpdate,
  output logic           naUpdate
);
  localparam int NA_W   = N_W + A_W;
  localparam int DATA_W = (R_W > NA_W) ? R_W : NA_W;
  localparam int SR_W   = DATA_W + 1;

  logic [SR_W-1:0] shiftReg;
  logic [R_W-1:0]  rLatch;
  logic [N_W-1:0]  nLatch;
  logic [A_W-1:0]  aLatch;
  logic            ctlBit;

  assign ctlBit = shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[SR_W-2:0], strb.bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rLatch <= '0;
      nLatch <= '0;
      aLatch <= '0;
    end else if (strb.load) begin
      if (ctlBit) begin
        rLatch <= shiftReg[R_W:1];
      end else begin
        nLatch <= shiftReg[NA_W:A_W+1];
        aLatch <= shiftReg[A_W:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rUpdate  <= 1'b0;
      naUpdate <= 1'b0;
    end else begin
      rUpdate  <= strb.pulse & ctlBit;
      naUpdate <= strb.pulse & ~ctlBit;
    end
  end

  assign rValue = rLatch;
  assign nValue = nLatch;
  assign aValue = aLatch;

  // R2: no shift-clock edge, no change in the shift register
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(shiftReg));
  // R5: enable low keeps every held value
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(rLatch) && $stable(nLatch) && $stable(aLatch)));
  // R6: a reference load leaves the pair alone
  a_r6_r_spares_na: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && ctlBit) |=> ($stable(nLatch) && $stable(aLatch)));
  // R6: a pair load leaves the reference alone
  a_r6_na_spares_r: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !ctlBit) |=> $stable(rLatch));
  // R7: strobes exclusive and one cycle wide
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rUpdate && naUpdate));
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (rUpdate || naUpdate) |=> !(rUpdate || naUpdate));
endmodule

// File: rtl/divLatchLoader.sv
module divLatchLoader
  import divLoadPkg::*;
#(
  parameter int R_W         = 14,
  parameter int N_W         = 10,
  parameter int A_W         = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sclkIn,
  input  logic           sdataIn,
  input  logic           latchEnIn,
  output logic [R_W-1:0] rValue,
  output logic [N_W-1:0] nValue,
  output logic [A_W-1:0] aValue,
  output logic           rUpdate,
  output logic           naUpdate
);
  ctrlStrobes_t strb;

  divLoadCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdataIn(sdataIn),
    .latchEnIn(latchEnIn), .strb(strb)
  );

  divLoadDatapath #(.R_W(R_W), .N_W(N_W), .A_W(A_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rValue(rValue), .nValue(nValue), .aValue(aValue),
    .rUpdate(rUpdate), .naUpdate(naUpdate)
  );
endmodule

// File: tb/divLatchLoader_tb.sv
`timescale 1ns/1ps
module divLatchLoader_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, en = 1'b0;
  logic [13:0] rValue;
  logic [9:0]  nValue;
  logic [6:0]  aValue;
  logic rUpdate, naUpdate;
  int total = 0, bad = 0;
  int rCnt = 0, naCnt = 0;
  logic [13:0] expR = '0;
  logic [9:0]  expN = '0;
  logic [6:0]  expA = '0;

  always #2.5 clk = ~clk;

  divLatchLoader u_dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .sdataIn(sdata), .latchEnIn(en),
    .rValue(rValue), .nValue(nValue), .aValue(aValue),
    .rUpdate(rUpdate), .naUpdate(naUpdate)
  );

  always @(posedge clk) begin
    if (rUpdate)  rCnt  <= rCnt + 1;
    if (naUpdate) naCnt <= naCnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdata = b; waitc(4);
    sclk = 1'b1; waitc(4);
    sclk = 1'b0; waitc(4);
  endtask

  task automatic sendR(input logic [13:0] v);
    for (int i = 13; i >= 0; i--) sbit(v[i]);
    sbit(1'b1);
  endtask

  task automatic sendNA(input logic [9:0] n, input logic [6:0] a);
    for (int i = 9; i >= 0; i--) sbit(n[i]);
    for (int i = 6; i >= 0; i--) sbit(a[i]);
    sbit(1'b0);
  endtask

  task automatic pulseEn();
    en = 1'b1; waitc(8);
    en = 1'b0; waitc(8);
  endtask

  task automatic checkAll(input string req);
    check(req, rValue, expR);
    check(req, nValue, expN);
    check(req, aValue, expA);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rPre, naPre;
    waitc(5);
    // R1: reset state
    checkAll("R1");
    check("R1 rUpdate", rUpdate, 0);
    check("R1 naUpdate", naUpdate, 0);
    rstN = 1'b1;
    waitc(4);

    // R3/R6/R7: reference sweep
    for (int k = 0; k < 20; k++) begin
      logic [13:0] v;
      v = (k < 14) ? 14'(1 << k) : 14'((k * 5461 + 77) & 'h3fff);
      sendR(v);
      rPre = rCnt; naPre = naCnt;
      pulseEn();
      expR = v;
      check("R3 rValue", rValue, expR);
      check("R6 nValue", nValue, expN);
      check("R6 aValue", aValue, expA);
      check("R7 rUpdate count", rCnt, rPre + 1);
      check("R7 naUpdate count", naCnt, naPre);
    end

    // R4/R6/R7: main/aux sweep
    for (int k = 0; k < 20; k++) begin
      logic [9:0] n;
      logic [6:0] a;
      n = (k < 10) ? 10'(1 << k) : 10'((k * 397 + 13) & 'h3ff);
      a = (k < 7) ? 7'(1 << (6 - k)) : 7'((k * 37 + 5) & 'h7f);
      sendNA(n, a);
      rPre = rCnt; naPre = naCnt;
      pulseEn();
      expN = n; expA = a;
      check("R4 nValue", nValue, expN);
      check("R4 aValue", aValue, expA);
      check("R6 rValue", rValue, expR);
      check("R7 naUpdate count", naCnt, naPre + 1);
      check("R7 rUpdate count", rCnt, rPre);
    end

    // R5: shifting with enable low changes nothing
    rPre = rCnt; naPre = naCnt;
    sendR(14'h2a5c);
    checkAll("R5 after R frame");
    sendNA(10'h3c3, 7'h5a);
    checkAll("R5 after NA frame");
    check("R5 no strobe", rCnt + naCnt, rPre + naPre);

    // R8: leading bits fall off the far end
    for (int j = 0; j < 7; j++) sbit(1'b1);
    sendR(14'h0421);
    pulseEn();
    expR = 14'h0421;
    checkAll("R8 leading R");
    for (int j = 0; j < 5; j++) sbit(1'b1);
    sendNA(10'h011, 7'h02);
    pulseEn();
    expN = 10'h011; expA = 7'h02;
    checkAll("R8 leading NA");

    // R2: data toggles without shift-clock edges do not shift
    sendNA(10'h2b6, 7'h4d);
    for (int j = 0; j < 10; j++) begin sdata = ~sdata; waitc(4); end
    pulseEn();
    expN = 10'h2b6; expA = 7'h4d;
    checkAll("R2 no shift on data toggle");

    // R9: enable held high, target follows, no extra strobe
    rPre = rCnt; naPre = naCnt;
    en = 1'b1; waitc(8);
    sendR(14'h1e0f);
    waitc(8);
    check("R9 rValue follows", rValue, 14'h1e0f);
    check("R9 single strobe", (rCnt + naCnt), rPre + naPre + 1);
    en = 1'b0; waitc(8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule